// File: doc/BRIEF.md
# Row-Ordered Hit Delta Encoder

This block sits between a pixel region's zero-suppressed hit source and three entropy coders. Hits arrive in column order, one per cycle. Each hit carries a column, a row and an ADC sample, and a flag marks the final hit of an event. The block keeps the hits in one queue per row, built as linked lists over a shared hit store. Each queue holds the column and ADC of its entries in the order they arrived.

When the final hit has been accepted, the input stalls and the block drains the row queues from the lowest occupied row upward. Rows that hold no hits cost no cycles. For each hit it emits a tuple: the column step and row step from the previously emitted hit, plus the ADC value. The dx, dy and ADC fields leave on separate buses so that three coders can take them in parallel. The first hit of each event is measured from the origin. The final tuple is flagged, and a per-event overflow flag goes with every tuple of an event that lost hits.

Top module: `rowDeltaEncoder`

## Requirements
- R1: After reset, outValid is 0 and inReady is 1.
- R2: The first tuple of every event carries dx equal to its column and dy equal to its row, so the previous position is taken as (0,0).
- R3: Tuples leave in increasing row order. Hits that share a row leave in the order they were accepted.
- R4: dx and dy are the column and row of the emitted hit minus those of the previously emitted hit of the same event. They are two's-complement values of $clog2(NUM_COLS)+1 and $clog2(NUM_ROWS)+1 bits.
- R5: outAdc equals the ADC value that was accepted with the hit.
- R6: Exactly one tuple leaves per stored hit, and outLast is 1 on the final one only. With outReady held at 1, the tuples leave on consecutive cycles whatever rows lie empty between them. outValid drops after the final handshake.
- R7: inReady is 1 while the block collects hits. It is 0 from the cycle after the hit flagged last is accepted until the final tuple is loaded.
- R8: A hit accepted while HIT_CAP hits are already stored is dropped. outOverflow is then 1 on every tuple of that event and 0 on the tuples of events that dropped nothing.
- R9: While outValid is 1 and outReady is 0, outValid, outDx, outDy, outAdc, outLast and outOverflow hold their values.
- R10: Each event starts from an empty store, with the origin as the previous position and the overflow flag clear, whatever happened in the event before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Hit present |
| inReady | output | 1 | Block can accept a hit |
| inCol | input | $clog2(NUM_COLS) | Hit column |
| inRow | input | $clog2(NUM_ROWS) | Hit row |
| inAdc | input | ADC_W | Hit ADC value |
| inLast | input | 1 | Hit is the final hit of its event |
| outValid | output | 1 | Tuple present |
| outReady | input | 1 | Consumer takes the tuple |
| outDx | output | $clog2(NUM_COLS)+1 | Signed column step |
| outDy | output | $clog2(NUM_ROWS)+1 | Signed row step |
| outAdc | output | ADC_W | ADC value |
| outLast | output | 1 | Final tuple of the event |
| outOverflow | output | 1 | Event dropped hits |

## Verification
The bench builds the block with a 16 by 16 region, 5-bit ADC values and a hit capacity of 6. The small capacity lets a nine-hit event run into the drop path. The narrow coordinates make the largest negative column step, -15, wrap into the 5-bit field. With only 16 rows, events can leave wide empty gaps between occupied rows, put several hits on one row, and hit both the top and bottom rows. That exercises the gap-free drain and the ordering within a row. Events follow one another directly, so any state left over from an overflowing event would show in the next one.

// File: rtl/rowDeltaPkg.sv
package rowDeltaPkg;

  typedef enum logic {
    S_COLLECT = 1'b0,
    S_DRAIN   = 1'b1
  } encState_e;

  typedef struct packed {
    logic append;   // store the presented hit
    logic markOvf;  // hit presented while store is full
    logic pop;      // take the head of the lowest occupied row
    logic endEvt;   // the pop is the final one of the event
  } encStrobe_t;

endpackage

// File: rtl/rowDeltaCtrl.sv
module rowDeltaCtrl
  import rowDeltaPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       inLast,
  input  logic       outReady,
  input  logic       outValid,
  input  logic       storeFull,
  input  logic       anyOcc,
  input  logic       popIsLast,
  output logic       inReady,
  output encStrobe_t strobe
);

  encState_e state, stateNext;
  logic      accept;
  logic      slotFree;

  assign inReady  = (state == S_COLLECT);
  assign accept   = inReady && inValid;
  assign slotFree = !outValid || outReady;

  always_comb begin
    strobe         = '0;
    stateNext      = state;
    strobe.append  = accept && !storeFull;
    strobe.markOvf = accept && storeFull;
    if (accept && inLast) stateNext = S_DRAIN;
    if (state == S_DRAIN && anyOcc && slotFree) begin
      strobe.pop = 1'b1;
      if (popIsLast) begin
        strobe.endEvt = 1'b1;
        stateNext     = S_COLLECT;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_COLLECT;
    else       state <= stateNext;
  end

  // R6: a draining block always has a stored hit to emit
  p_drain_nonempty_r6: assert property (@(posedge clk) disable iff (!rstN)
    state == S_DRAIN |-> anyOcc);

endmodule

// File: rtl/rowDeltaPath.sv
module rowDeltaPath
  import rowDeltaPkg::*;
#(
  parameter int NUM_COLS = 32,
  parameter int NUM_ROWS = 64,
  parameter int ADC_W    = 5,
  parameter int HIT_CAP  = 100
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  encStrobe_t           strobe,
  input  logic [$clog2(NUM_COLS)-1:0] inCol,
  input  logic [$clog2(NUM_ROWS)-1:0] inRow,
  input  logic [ADC_W-1:0]     inAdc,
  input  logic                 outReady,
  output logic                 storeFull,
  output logic                 anyOcc,
  output logic                 popIsLast,
  output logic                 outValid,
  output logic [$clog2(NUM_COLS):0] outDx,
  output logic [$clog2(NUM_ROWS):0] outDy,
  output logic [ADC_W-1:0]     outAdc,
  output logic                 outLast,
  output logic                 outOverflow
);

  localparam int COL_W = $clog2(NUM_COLS);
  localparam int ROW_W = $clog2(NUM_ROWS);
  localparam int IDX_W = (HIT_CAP > 1) ? $clog2(HIT_CAP) : 1;
  localparam int CNT_W = $clog2(HIT_CAP + 1);

  // shared hit store with one linked list per row
  logic [COL_W-1:0] entCol  [HIT_CAP];
  logic [ADC_W-1:0] entAdc  [HIT_CAP];
  logic [IDX_W-1:0] entNext [HIT_CAP];
  logic [IDX_W-1:0] rowHead [NUM_ROWS];
  logic [IDX_W-1:0] rowTail [NUM_ROWS];
  logic [NUM_ROWS-1:0] rowOcc;

  logic [CNT_W-1:0] wrCnt;
  logic [IDX_W-1:0] wrIdx;
  logic             evtOvf;
  logic [COL_W-1:0] prevCol;
  logic [ROW_W-1:0] prevRow;

  logic [ROW_W-1:0] selRow;
  logic [IDX_W-1:0] selIdx;
  logic             rowEmpties;

  assign storeFull = (wrCnt == CNT_W'(HIT_CAP));
  assign wrIdx     = IDX_W'(wrCnt);
  assign anyOcc    = |rowOcc;

  // lowest occupied row
  always_comb begin
    selRow = '0;
    for (int i = NUM_ROWS - 1; i >= 0; i--) begin
      if (rowOcc[i]) selRow = ROW_W'(i);
    end
  end

  assign selIdx     = rowHead[selRow];
  assign rowEmpties = (selIdx == rowTail[selRow]);
  assign popIsLast  = rowEmpties && ((rowOcc & (rowOcc - 1'b1)) == '0) && anyOcc;

  // payload memories, no reset needed
  always_ff @(posedge clk) begin
    if (strobe.append) begin
      entCol[wrIdx] <= inCol;
      entAdc[wrIdx] <= inAdc;
      if (rowOcc[inRow]) entNext[rowTail[inRow]] <= wrIdx;
    end
  end

  // row list pointers
  always_ff @(posedge clk) begin
    if (strobe.append) begin
      rowTail[inRow] <= wrIdx;
      if (!rowOcc[inRow]) rowHead[inRow] <= wrIdx;
    end else if (strobe.pop && !rowEmpties) begin
      rowHead[selRow] <= entNext[selIdx];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowOcc <= '0;
      wrCnt  <= '0;
      evtOvf <= 1'b0;
    end else begin
      if (strobe.append) begin
        rowOcc[inRow] <= 1'b1;
        wrCnt         <= wrCnt + 1'b1;
      end
      if (strobe.markOvf) evtOvf <= 1'b1;
      if (strobe.pop && rowEmpties) rowOcc[selRow] <= 1'b0;
      if (strobe.endEvt) begin
        wrCnt  <= '0;
        evtOvf <= 1'b0;
      end
    end
  end

  // output register and running position
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid    <= 1'b0;
      outDx       <= '0;
      outDy       <= '0;
      outAdc      <= '0;
      outLast     <= 1'b0;
      outOverflow <= 1'b0;
      prevCol     <= '0;
      prevRow     <= '0;
    end else if (strobe.pop) begin
      outValid    <= 1'b1;
      outDx       <= {1'b0, entCol[selIdx]} - {1'b0, prevCol};
      outDy       <= {1'b0, selRow} - {1'b0, prevRow};
      outAdc      <= entAdc[selIdx];
      outLast     <= strobe.endEvt;
      outOverflow <= evtOvf;
      prevCol     <= strobe.endEvt ? '0 : entCol[selIdx];
      prevRow     <= strobe.endEvt ? '0 : selRow;
    end else if (outReady) begin
      outValid    <= 1'b0;
    end
  end

  // R8: control never stores into a full store
  p_append_room_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.append |-> !storeFull);

  // R8: a dropped hit marks its event
  p_ovf_flag_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.markOvf |=> evtOvf);

  // R10: the store and running position are clear once an event ends
  p_event_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.endEvt |=> (!anyOcc && prevCol == '0 && prevRow == '0 && !evtOvf));

  // R9: a stalled tuple holds
  p_hold_tuple_r9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outDx) && $stable(outDy)
      && $stable(outAdc) && $stable(outLast) && $stable(outOverflow)));

endmodule

// File: rtl/rowDeltaEncoder.sv
module rowDeltaEncoder
  import rowDeltaPkg::*;
#(
  parameter int NUM_COLS = 32,
  parameter int NUM_ROWS = 64,
  parameter int ADC_W    = 5,
  parameter int HIT_CAP  = 100
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        inValid,
  output logic                        inReady,
  input  logic [$clog2(NUM_COLS)-1:0] inCol,
  input  logic [$clog2(NUM_ROWS)-1:0] inRow,
  input  logic [ADC_W-1:0]            inAdc,
  input  logic                        inLast,
  output logic                        outValid,
  input  logic                        outReady,
  output logic [$clog2(NUM_COLS):0]   outDx,
  output logic [$clog2(NUM_ROWS):0]   outDy,
  output logic [ADC_W-1:0]            outAdc,
  output logic                        outLast,
  output logic                        outOverflow
);

  encStrobe_t strobe;
  logic       storeFull;
  logic       anyOcc;
  logic       popIsLast;

  rowDeltaCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .inLast    (inLast),
    .outReady  (outReady),
    .outValid  (outValid),
    .storeFull (storeFull),
    .anyOcc    (anyOcc),
    .popIsLast (popIsLast),
    .inReady   (inReady),
    .strobe    (strobe)
  );

  rowDeltaPath #(
    .NUM_COLS (NUM_COLS),
    .NUM_ROWS (NUM_ROWS),
    .ADC_W    (ADC_W),
    .HIT_CAP  (HIT_CAP)
  ) u_path (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .inCol       (inCol),
    .inRow       (inRow),
    .inAdc       (inAdc),
    .outReady    (outReady),
    .storeFull   (storeFull),
    .anyOcc      (anyOcc),
    .popIsLast   (popIsLast),
    .outValid    (outValid),
    .outDx       (outDx),
    .outDy       (outDy),
    .outAdc      (outAdc),
    .outLast     (outLast),
    .outOverflow (outOverflow)
  );

endmodule

// File: tb/rowDeltaEncoder_tb.sv
module rowDeltaEncoder_tb;

  localparam int NC  = 16;
  localparam int NR  = 16;
  localparam int AW  = 5;
  localparam int CAP = 6;
  localparam int DXM = 31;  // 5-bit dx/dy masks
  localparam int DYM = 31;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inLast = 1'b0, outReady = 1'b0;
  logic [3:0] inCol = '0, inRow = '0;
  logic [AW-1:0] inAdc = '0;
  logic inReady, outValid, outLast, outOverflow;
  logic [4:0] outDx, outDy;
  logic [AW-1:0] outAdc;

  int vecCnt = 0;
  int errCnt = 0;
  int cycCnt = 0;

  int hCol[16], hRow[16], hAdc[16];
  int eCol[16], eRow[16], eAdc[16];

  always #2 clk = ~clk;  // 250 MHz

  rowDeltaEncoder #(.NUM_COLS(NC), .NUM_ROWS(NR), .ADC_W(AW), .HIT_CAP(CAP)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inCol(inCol), .inRow(inRow), .inAdc(inAdc), .inLast(inLast),
    .outValid(outValid), .outReady(outReady), .outDx(outDx), .outDy(outDy),
    .outAdc(outAdc), .outLast(outLast), .outOverflow(outOverflow));

  task automatic check(input string tag, input int act, input int exp);
    vecCnt++;
    if (act != exp) begin
      errCnt++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic setHit(input int i, input int c, input int r, input int a);
    hCol[i] = c; hRow[i] = r; hAdc[i] = a;
  endtask

  // send n hits, then drain with outReady taken from readyPat bits
  task automatic runEvent(input string name, input int n, input logic [31:0] readyPat);
    int m, k, pc, pr, cyc, firstCyc, lastCyc;
    int hD, hY, hA, hL, hO;
    bit held, ovf;
    m   = (n > CAP) ? CAP : n;
    ovf = (n > CAP);
    k   = 0;
    for (int r = 0; r < NR; r++)
      for (int i = 0; i < m; i++)
        if (hRow[i] == r) begin eCol[k] = hCol[i]; eRow[k] = r; eAdc[k] = hAdc[i]; k++; end
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == 0) check({name, " R7 inReady while collecting"}, int'(inReady), 1);
      inValid = 1'b1; inCol = 4'(hCol[i]); inRow = 4'(hRow[i]);
      inAdc = AW'(hAdc[i]); inLast = (i == n - 1);
    end
    @(negedge clk);
    inValid = 1'b0; inLast = 1'b0;
    check({name, " R7 inReady low after last hit"}, int'(inReady), 0);
    k = 0; pc = 0; pr = 0; cyc = 0; held = 0; firstCyc = -1; lastCyc = 0;
    hD = 0; hY = 0; hA = 0; hL = 0; hO = 0;
    while (k < m && cyc < 2000) begin
      outReady = readyPat[cyc % 32];
      if (outValid) begin
        if (firstCyc < 0) firstCyc = cyc;
        if (held) begin
          check({name, " R9 hold dx"}, int'(outDx), hD);
          check({name, " R9 hold dy"}, int'(outDy), hY);
          check({name, " R9 hold adc/last/ovf"}, int'({outAdc, outLast, outOverflow}), (hA << 2) | (hL << 1) | hO);
        end
        if (outReady) begin
          check({name, " R4 dx"}, int'(outDx), (eCol[k] - pc) & DXM);
          check({name, " R3 dy row order"}, int'(outDy), (eRow[k] - pr) & DYM);
          check({name, " R5 adc"}, int'(outAdc), eAdc[k]);
          check({name, " R6 last flag"}, int'(outLast), int'(k == m - 1));
          check({name, " R8 overflow flag"}, int'(outOverflow), int'(ovf));
          if (k < m - 1) check({name, " R7 inReady low in drain"}, int'(inReady), 0);
          pc = eCol[k]; pr = eRow[k]; k++; held = 0; lastCyc = cyc;
        end else begin
          held = 1;
          hD = int'(outDx); hY = int'(outDy); hA = int'(outAdc);
          hL = int'(outLast); hO = int'(outOverflow);
        end
      end
      @(negedge clk);
      cyc++;
    end
    outReady = 1'b0;
    check({name, " R6 tuple count"}, k, m);
    if (readyPat == '1) check({name, " R6 no gap cycles"}, lastCyc - firstCyc, m - 1);
    check({name, " R6 valid drops after last"}, int'(outValid), 0);
    check({name, " R7 inReady back"}, int'(inReady), 1);
  endtask

  task automatic testReset();
    check("R1 outValid after reset", int'(outValid), 0);
    check("R1 inReady after reset", int'(inReady), 1);
  endtask

  task automatic testSingle();
    setHit(0, 5, 9, 17);
    runEvent("single R2", 1, '1);
  endtask

  task automatic testRowSort();
    // column-ordered arrival, rows scattered with gaps and repeats
    setHit(0, 1, 12, 3);
    setHit(1, 2, 0, 30);
    setHit(2, 4, 12, 7);
    setHit(3, 6, 5, 1);
    setHit(4, 9, 15, 31);
    setHit(5, 11, 5, 0);
    runEvent("rowsort R3", 6, '1);
  endtask

  task automatic testNegSteps();
    // large negative column step and row step into the top row
    setHit(0, 15, 3, 9);
    setHit(1, 0, 3, 10);
    setHit(2, 15, 15, 11);
    runEvent("negstep R4", 3, '1);
  endtask

  task automatic testBackpressure();
    setHit(0, 3, 7, 4);
    setHit(1, 3, 2, 5);
    setHit(2, 8, 7, 6);
    setHit(3, 10, 1, 8);
    runEvent("stall R9", 4, 32'b1001_0110_0011_0100_1100_1010_0110_0100);
  endtask

  task automatic testOverflow();
    for (int i = 0; i < 9; i++) setHit(i, i, (9 - i) % 4, i + 1);
    runEvent("ovf R8", 9, '1);
    // following event starts clean
    setHit(0, 7, 6, 2);
    setHit(1, 12, 1, 20);
    runEvent("after ovf R10", 2, 32'h5555_5555);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSingle();
    testRowSort();
    testNegSteps();
    testBackpressure();
    testOverflow();
    $display("  == %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end

  always @(posedge clk) begin
    cycCnt++;
    if (cycCnt > 100000) begin
      errCnt++;
      $display("FAIL watchdog actual=%0d expected=0", cycCnt);
      $display("  == %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
      $finish;
    end
  end

endmodule